// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from a set of on-chip sources and four off-chip lines, and presents them to a processor on a normal request output. A separate fast request output is driven by a single dedicated off-chip input and by nothing else. Every normal-path source has its own enable bit, a priority level from 0 to 7 and a trigger mode. On-chip sources can be level- or edge-sensitive. Off-chip lines can be high-level, low-level, rising-edge or falling-edge sensitive. Off-chip lines pass through a two-stage synchronizer before any detection.

Software reads a vector register to get the handler address that was programmed for the winning source. That read also acknowledges the source. It pushes the source's level onto an internal level stack and clears the source's latched edge. While the stack is not empty, only sources whose level is strictly above the top of the stack can raise the normal request. This gives nesting by priority. Writing the end-of-interrupt register pops one level off the stack.

Registers are reached through a flat 8-bit address port. Writes take effect on the clock edge. Reads are combinational.

| Address | Name | Access | Meaning |
|---|---|---|---|
| 0x00 | Enable | read/write | One bit per source |
| 0x01 | Vector | read | Vector of the winning source; the read acknowledges it |
| 0x02 | End-of-interrupt | write | Pops one level off the stack |
| 0x03 | Pending | read | Raw pending bits, before the enable mask |
| 0x04 | Status | read | Stack depth in bits [3:0], top level in bits [11:8] |
| 0x10+i | Configuration of source i | read/write | Level in bits [2:0], trigger mode in bits [5:4] |
| 0x20+i | Vector of source i | read/write | Handler address of source i |

In the trigger mode field, bit 4 selects edge (1) or level (0). Bit 5 selects active-high or rising (1), or active-low or falling (0).

Sources 0 to N_INT-1 are on-chip. Sources from N_INT upward are off-chip.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the following hold:
  - both request outputs are low;
  - the enable register reads 0;
  - the status register reads 0, meaning the stack is empty;
  - every source configuration reads 0x20, which is level 0 in high-level mode.
- R2: A source whose enable bit is 0 never raises the normal request and is never selected by a vector read, even while it is pending.
- R3: Among eligible sources, the one with the highest level wins. When levels are equal, the lower-numbered source wins.
- R4: A vector read returns the programmed vector of the winning source. When no source is eligible, it returns the spurious value 0xFFFF_FFF0 and changes no state.
- R5: The two modes of an on-chip source behave as follows:
  - For an on-chip source, the polarity bit (bit 5) of a configuration write is ignored and reads back as 1.
  - An on-chip level source is pending in the same cycle its input is high.
  - An on-chip edge source becomes pending one clock edge after its input rises.
- R6: Each of the four modes of an off-chip line behaves as follows:
  - 0 (low level): pending while the synchronized line is low;
  - 1 (falling edge): pending is latched on a synchronized high-to-low change;
  - 2 (high level): pending while the synchronized line is high;
  - 3 (rising edge): pending is latched on a synchronized low-to-high change.
- R7: An off-chip level change reaches the normal request after two clock edges. An off-chip edge reaches it after three clock edges.
- R8: Acknowledging a source clears its latched edge. A level source stays pending for as long as its input stays active.
- R9: A vector read that finds a winner pushes the winner's level onto the stack. While the stack is not empty, only sources at a level strictly above the top of the stack can raise the normal request.
- R10: An end-of-interrupt write pops one stack entry. On an empty stack it has no effect.
- R11: The fast request output follows the fast input after two clock edges. Enables, the stack and vector reads have no effect on it.
- R12: An edge detected while its source is masked stays latched, and it raises the normal request as soon as the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_src_i | input | N_INT | On-chip interrupt sources, already in the clock domain |
| ext_src_i | input | N_EXT | Off-chip interrupt lines, asynchronous |
| fast_src_i | input | 1 | Dedicated off-chip fast interrupt line, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; it has a side effect only on the vector register |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: four on-chip sources, four off-chip lines, 3-bit levels and two synchronizer stages. This puts all eight levels within reach, together with ties that cross the on-chip/off-chip boundary and every trigger mode of both source kinds. With only eight sources, each test can reprogram every configuration register, so the priority table can place the winner on either side of the boundary. The nesting tests push two distinct levels and pop them again. They also show that an equal-level source stays blocked while a higher one breaks through.

// File: rtl/irq_ctrl_pkg.sv
// Package irq_ctrl_pkg: register addresses and trigger-mode encoding shared
// by the interrupt controller modules.
package irq_ctrl_pkg;

    // Trigger mode: bit0 = edge (1) / level (0); bit1 = active-high/rising (1)
    typedef enum logic [1:0] {
        TRIG_LOW_LVL  = 2'b00,
        TRIG_FALL     = 2'b01,
        TRIG_HIGH_LVL = 2'b10,
        TRIG_RISE     = 2'b11
    } trig_e;

    localparam logic [7:0] ADDR_ENABLE = 8'h00;
    localparam logic [7:0] ADDR_VECTOR = 8'h01;
    localparam logic [7:0] ADDR_EOI    = 8'h02;
    localparam logic [7:0] ADDR_PEND   = 8'h03;
    localparam logic [7:0] ADDR_STATUS = 8'h04;
    localparam logic [3:0] PAGE_CFG    = 4'h1;
    localparam logic [3:0] PAGE_VEC    = 4'h2;

    localparam int MODE_LSB = 4;

endpackage

// File: rtl/irq_sync.sv
// Module irq_sync: a chain of STAGES flops per bit that brings asynchronous
// lines into the clk domain.
// Assumes: each bit is independent; no multi-bit coherency is needed.
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[0] <= '0;
                else        stg_q[0] <= d_i;
            end
        end else begin : g_next
            // Later stages shift the value along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
// Module irq_detect: per-source trigger detection. A level-mode source is
// pending while its input is active. An edge-mode source latches a pending
// bit on the selected edge, and an acknowledge clears that bit.
// Assumes: inputs are already synchronous; mode bit0 = edge, bit1 = high/rising.
module irq_detect #(
    parameter int NSRC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [2*NSRC-1:0] mode_i,
    input  logic [NSRC-1:0]   ack_i,
    output logic [NSRC-1:0]   pend_o
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic prev_q;
        logic epend_q;
        logic is_edge;
        logic act_hi;
        logic edge_seen;

        assign is_edge   = mode_i[2*g];
        assign act_hi    = mode_i[2*g+1];
        assign edge_seen = act_hi ? (src_i[g] & ~prev_q) : (~src_i[g] & prev_q);

        // Remembers the previous input value for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_i[g];
        end

        // Edge-pending latch: a new edge wins over an acknowledge in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n)         epend_q <= 1'b0;
            else if (!is_edge)  epend_q <= 1'b0;
            else if (edge_seen) epend_q <= 1'b1;
            else if (ack_i[g])  epend_q <= 1'b0;
        end

        assign pend_o[g] = is_edge ? epend_q : (act_hi ? src_i[g] : ~src_i[g]);

        // R8: an acknowledge with no new edge leaves the edge bit clear
        a_r8_ack_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[g] && is_edge && !edge_seen) |=> !pend_o[g] || edge_seen);

        // R6: a detected edge is latched until it is acknowledged
        a_r6_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
            (is_edge && edge_seen) |=> (pend_o[g] || !is_edge));
    end

endmodule

// File: rtl/irq_prio.sv
// Module irq_prio: picks the eligible source with the highest level. When
// levels are equal, the lower index wins.
// Assumes: NSRC >= 2; cand_i is already gated by enable and the nesting threshold.
module irq_prio #(
    parameter int NSRC  = 8,
    parameter int LVL_W = 3,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]       cand_i,
    input  logic [NSRC*LVL_W-1:0] lvl_i,
    output logic                  valid_o,
    output logic [IDX_W-1:0]      idx_o,
    output logic [LVL_W-1:0]      lvl_o
);

    // Linear scan; strict comparison keeps the earliest index on ties
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand_i[i] && (!valid_o || lvl_i[i*LVL_W +: LVL_W] > lvl_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_lvl_stack.sv
// Module irq_lvl_stack: a stack of the priority levels in service. Push
// stores the level of an acknowledged source. Pop removes the newest entry,
// and a pop on an empty stack is ignored.
// Assumes: push and pop are never requested in the same cycle.
module irq_lvl_stack #(
    parameter int LVL_W = 3,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [CNT_W-1:0] depth_o,
    output logic [LVL_W-1:0] top_o,
    output logic             empty_o
);

    logic [LVL_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_m1;

    assign cnt_m1 = cnt_q - CNT_W'(1);

    // Stores the pushed level at the current fill position
    always_ff @(posedge clk) begin
        if (push_i && cnt_q < CNT_W'(DEPTH)) mem_q[cnt_q[PTR_W-1:0]] <= push_lvl_i;
    end

    // Fill counter: increments on push, decrements on pop when not empty
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (push_i && cnt_q < CNT_W'(DEPTH))     cnt_q <= cnt_q + CNT_W'(1);
        else if (pop_i && cnt_q != '0)                cnt_q <= cnt_m1;
    end

    assign depth_o = cnt_q;
    assign empty_o = (cnt_q == '0);
    assign top_o   = empty_o ? '0 : mem_q[cnt_m1[PTR_W-1:0]];

    // R9: strictly increasing levels bound the depth, so no push finds the stack full
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < CNT_W'(DEPTH)));

    // R10: a pop on an empty stack leaves it empty
    a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module prio_irq_ctrl: a vectored interrupt controller with priority levels.
// A normal request is made from the enabled, triggered sources. A fast
// request is made from one dedicated line only. A vector read acknowledges
// the winner and nests by level; an end-of-interrupt write pops the nesting.
// Assumes: NSRC <= 16 and LVL_W <= 4, so that the register map fits;
// on-chip sources are synchronous to clk.
module prio_irq_ctrl #(
    parameter int          N_INT       = 4,
    parameter int          N_EXT       = 4,
    parameter int          LVL_W       = 3,
    parameter int          VEC_W       = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] SPUR_VEC    = 32'hFFFF_FFF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] int_src_i,
    input  logic [N_EXT-1:0] ext_src_i,
    input  logic             fast_src_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [7:0]       reg_addr_i,
    input  logic [31:0]      reg_wdata_i,
    output logic [31:0]      reg_rdata_o,
    output logic             irq_o,
    output logic             fiq_o
);
    import irq_ctrl_pkg::*;

    localparam int NSRC   = N_INT + N_EXT;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int DEPTH  = 2 ** LVL_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    // ---- synchronizers ----
    logic [N_EXT-1:0] ext_sync;
    logic             fast_sync;

    irq_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ext_src_i), .q_o(ext_sync));

    irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_fast_sync (
        .clk(clk), .rst_n(rst_n), .d_i(fast_src_i), .q_o(fast_sync));

    assign fiq_o = fast_sync;

    // ---- configuration registers ----
    logic [NSRC-1:0]  en_q;
    logic [LVL_W-1:0] lvl_q  [NSRC];
    logic [1:0]       mode_q [NSRC];
    logic [VEC_W-1:0] vec_q  [NSRC];

    logic       wr_cfg, wr_vec;
    logic [3:0] sel_idx;

    assign sel_idx = reg_addr_i[3:0];
    assign wr_cfg  = reg_wr_i && (reg_addr_i[7:4] == PAGE_CFG);
    assign wr_vec  = reg_wr_i && (reg_addr_i[7:4] == PAGE_VEC);

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)                                     en_q <= '0;
        else if (reg_wr_i && reg_addr_i == ADDR_ENABLE) en_q <= reg_wdata_i[NSRC-1:0];
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_cfg
        // Per-source level and trigger mode; on-chip sources keep polarity at 1
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i]  <= '0;
                mode_q[i] <= TRIG_HIGH_LVL;
            end else if (wr_cfg && sel_idx == 4'(i)) begin
                lvl_q[i] <= reg_wdata_i[LVL_W-1:0];
                if (i < N_INT) mode_q[i] <= {1'b1, reg_wdata_i[MODE_LSB]};
                else           mode_q[i] <= reg_wdata_i[MODE_LSB +: 2];
            end
        end

        // Per-source handler vector
        always_ff @(posedge clk) begin
            if (!rst_n)                            vec_q[i] <= '0;
            else if (wr_vec && sel_idx == 4'(i))   vec_q[i] <= reg_wdata_i[VEC_W-1:0];
        end
    end

    // ---- flattening for the submodules ----
    logic [2*NSRC-1:0]     mode_flat;
    logic [NSRC*LVL_W-1:0] lvl_flat;

    for (genvar i = 0; i < NSRC; i++) begin : g_flat
        assign mode_flat[2*i +: 2]         = mode_q[i];
        assign lvl_flat[i*LVL_W +: LVL_W]  = lvl_q[i];
    end

    // ---- detection ----
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] ack;

    irq_detect #(.NSRC(NSRC)) u_detect (
        .clk(clk), .rst_n(rst_n), .src_i({ext_sync, int_src_i}),
        .mode_i(mode_flat), .ack_i(ack), .pend_o(pend));

    // ---- nesting stack ----
    logic             push, pop;
    logic [CNT_W-1:0] stk_depth;
    logic [LVL_W-1:0] stk_top;
    logic             stk_empty;
    logic [LVL_W-1:0] win_lvl;

    irq_lvl_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_lvl_i(win_lvl),
        .pop_i(pop), .depth_o(stk_depth), .top_o(stk_top), .empty_o(stk_empty));

    // ---- eligibility and priority ----
    logic [NSRC-1:0]  cand;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;

    // Eligible: pending, enabled, and above the level in service
    always_comb begin
        for (int i = 0; i < NSRC; i++)
            cand[i] = pend[i] && en_q[i] && (stk_empty || lvl_q[i] > stk_top);
    end

    irq_prio #(.NSRC(NSRC), .LVL_W(LVL_W)) u_prio (
        .cand_i(cand), .lvl_i(lvl_flat), .valid_o(win_valid),
        .idx_o(win_idx), .lvl_o(win_lvl));

    assign irq_o = win_valid;
    assign push  = reg_rd_i && (reg_addr_i == ADDR_VECTOR) && win_valid;
    assign pop   = reg_wr_i && (reg_addr_i == ADDR_EOI);
    assign ack   = push ? (NSRC'(1) << win_idx) : '0;

    // ---- read mux ----
    // Combinational read data selected by address
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_ENABLE)      reg_rdata_o = 32'(en_q);
        else if (reg_addr_i == ADDR_VECTOR) reg_rdata_o = win_valid ? 32'(vec_q[win_idx]) : SPUR_VEC;
        else if (reg_addr_i == ADDR_PEND)   reg_rdata_o = 32'(pend);
        else if (reg_addr_i == ADDR_STATUS) begin
            reg_rdata_o[CNT_W-1:0]   = stk_depth;
            reg_rdata_o[8 +: LVL_W]  = stk_top;
        end else if (reg_addr_i[7:4] == PAGE_CFG && sel_idx < 4'(NSRC)) begin
            reg_rdata_o[LVL_W-1:0]     = lvl_q[sel_idx[IDX_W-1:0]];
            reg_rdata_o[MODE_LSB +: 2] = mode_q[sel_idx[IDX_W-1:0]];
        end else if (reg_addr_i[7:4] == PAGE_VEC && sel_idx < 4'(NSRC))
            reg_rdata_o = 32'(vec_q[sel_idx[IDX_W-1:0]]);
    end

    // R9: an acknowledge only pushes a level above the one in service
    a_r9_push_higher: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (stk_empty || win_lvl > stk_top));

    // R2: the normal request never names a masked source
    a_r2_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en_q[win_idx]);

    // R4: a vector read with no winner leaves the stack depth unchanged
    a_r4_spurious_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_VECTOR && !irq_o && !pop) |=> $stable(stk_depth));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
// Bench for prio_irq_ctrl: a table-driven priority sweep followed by
// directed tests of trigger modes, nesting and the fast line.
module tb_prio_irq_ctrl;

    localparam logic [31:0] SPUR = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  int_src;
    logic [3:0]  ext_src;
    logic        fast_src;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .int_src_i(int_src), .ext_src_i(ext_src),
        .fast_src_i(fast_src), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_o(irq), .fiq_o(fiq));

    typedef struct packed {
        logic [23:0] lv;
        logic [7:0]  en;
        logic [3:0]  ii;
        logic [3:0]  ei;
        logic        v;
        logic [2:0]  idx;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{lv: 24'h0, en: 8'hFF, ii: 4'b0001, ei: 4'b0000, v: 1'b1, idx: 3'd0},
        '{lv: {3'd0,3'd0,3'd0,3'd0,3'd5,3'd0,3'd2,3'd0}, en: 8'hFF, ii: 4'b1010, ei: 4'b0000, v: 1'b1, idx: 3'd3},
        '{lv: {3'd0,3'd0,3'd0,3'd0,3'd5,3'd0,3'd2,3'd0}, en: 8'hF7, ii: 4'b1010, ei: 4'b0000, v: 1'b1, idx: 3'd1},
        '{lv: {8{3'd4}}, en: 8'hFF, ii: 4'b0110, ei: 4'b0001, v: 1'b1, idx: 3'd1},
        '{lv: {3'd0,3'd7,3'd0,3'd0,3'd0,3'd0,3'd0,3'd6}, en: 8'hFF, ii: 4'b0001, ei: 4'b0100, v: 1'b1, idx: 3'd6},
        '{lv: 24'h0, en: 8'hFF, ii: 4'b0000, ei: 4'b0000, v: 1'b0, idx: 3'd0},
        '{lv: {8{3'd1}}, en: 8'h00, ii: 4'b1111, ei: 4'b1111, v: 1'b0, idx: 3'd0},
        '{lv: {3'd3,3'd0,3'd0,3'd3,3'd0,3'd1,3'd0,3'd0}, en: 8'hFF, ii: 4'b0100, ei: 4'b1001, v: 1'b1, idx: 3'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; int_src = '0; ext_src = '0; fast_src = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) wr(8'h20 + 8'(i), 32'h100 + 32'(i));
    endtask

    task automatic tick_chk(input string req, input logic exp);
        @(negedge clk);
        #1 chk(req, 32'(irq), 32'(exp));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        rst_n = 0; int_src = 0; ext_src = 0; fast_src = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 irq in reset", 32'(irq), 32'd0);
        chk("R1 fiq in reset", 32'(fiq), 32'd0);
        rst_n = 1'b1;
        rd(8'h00, d); chk("R1 enable", d, 32'h0);
        rd(8'h10, d); chk("R1 cfg src0", d, 32'h20);
        rd(8'h14, d); chk("R1 cfg src4", d, 32'h20);
        rd(8'h04, d); chk("R1 status", d, 32'h0);
        rd(8'h01, d); chk("R4 spurious after reset", d, SPUR);
        rd(8'h04, d); chk("R4 spurious no push", d, 32'h0);

        // ---- table sweep: R2, R3, R4 ----
        do_reset();
        foreach (TBL[k]) begin
            for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i), 32'h20 | 32'(TBL[k].lv[3*i +: 3]));
            wr(8'h00, 32'(TBL[k].en));
            @(negedge clk);
            int_src = TBL[k].ii; ext_src = TBL[k].ei;
            repeat (3) @(negedge clk);
            #1 chk($sformatf("R2/R3 irq entry %0d", k), 32'(irq), 32'(TBL[k].v));
            rd(8'h01, d);
            chk($sformatf("R3/R4 vector entry %0d", k), d, TBL[k].v ? 32'h100 + 32'(TBL[k].idx) : SPUR);
            if (TBL[k].v) wr(8'h02, 0);
            @(negedge clk);
            int_src = '0; ext_src = '0;
            repeat (3) @(negedge clk);
        end

        // ---- R5 on-chip modes ----
        do_reset();
        wr(8'h10, 32'h00); rd(8'h10, d); chk("R5 polarity forced (level)", d, 32'h20);
        wr(8'h10, 32'h11); rd(8'h10, d); chk("R5 polarity forced (edge)", d, 32'h31);
        wr(8'h00, 32'h01);
        @(negedge clk); int_src[0] = 1'b1;
        #1 chk("R5 edge not immediate", 32'(irq), 32'd0);
        tick_chk("R5 internal edge one edge", 1'b1);
        rd(8'h01, d); chk("R5 vector src0", d, 32'h100);
        #1 chk("R8 edge cleared by ack", 32'(irq), 32'd0);
        wr(8'h02, 0);
        #1 chk("R8 edge stays cleared after EOI", 32'(irq), 32'd0);
        int_src[0] = 1'b0;
        wr(8'h11, 32'h22); wr(8'h00, 32'h02);
        @(negedge clk); int_src[1] = 1'b1;
        #1 chk("R5 internal level immediate", 32'(irq), 32'd1);
        @(negedge clk); int_src[1] = 1'b0;

        // ---- R6 / R7 off-chip modes ----
        do_reset();
        wr(8'h14, 32'h20); wr(8'h00, 32'h10);
        @(negedge clk); ext_src[0] = 1'b1;
        tick_chk("R7 level after 1 edge", 1'b0);
        tick_chk("R7 level after 2 edges", 1'b1);
        ext_src[0] = 1'b0;
        wr(8'h15, 32'h30); wr(8'h00, 32'h20);
        @(negedge clk); ext_src[1] = 1'b1;
        tick_chk("R7 edge after 1 edge", 1'b0);
        tick_chk("R7 edge after 2 edges", 1'b0);
        tick_chk("R7 rising after 3 edges", 1'b1);
        rd(8'h01, d); chk("R6 rising vector", d, 32'h105);
        #1 chk("R8 ext edge cleared", 32'(irq), 32'd0);
        wr(8'h02, 0);
        wr(8'h16, 32'h10);
        @(negedge clk); ext_src[2] = 1'b1;
        repeat (4) @(negedge clk);
        wr(8'h00, 32'h40);
        #1 chk("R6 falling ignores rise", 32'(irq), 32'd0);
        @(negedge clk); ext_src[2] = 1'b0;
        tick_chk("R6 falling after 1", 1'b0);
        tick_chk("R6 falling after 2", 1'b0);
        tick_chk("R6 falling after 3", 1'b1);
        wr(8'h17, 32'h00);
        @(negedge clk); ext_src[3] = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'h00, 32'h80);
        #1 chk("R6 low level idle high", 32'(irq), 32'd0);
        @(negedge clk); ext_src[3] = 1'b0;
        tick_chk("R6 low level after 1", 1'b0);
        tick_chk("R6 low level after 2", 1'b1);

        // ---- R8 level stays pending, R9 equal level blocked ----
        do_reset();
        wr(8'h00, 32'h01);
        @(negedge clk); int_src[0] = 1'b1;
        rd(8'h01, d); chk("R8 level vector", d, 32'h100);
        #1 chk("R9 same source held off", 32'(irq), 32'd0);
        wr(8'h02, 0);
        #1 chk("R8 level still pending after EOI", 32'(irq), 32'd1);
        int_src[0] = 1'b0;

        // ---- R9 / R10 nesting ----
        do_reset();
        wr(8'h10, 32'h22); wr(8'h11, 32'h22); wr(8'h12, 32'h25); wr(8'h00, 32'h07);
        @(negedge clk); int_src = 4'b0001;
        rd(8'h01, d); chk("R9 first ack", d, 32'h100);
        int_src = 4'b0011;
        tick_chk("R9 equal level blocked", 1'b0);
        int_src = 4'b0111;
        tick_chk("R9 higher level breaks through", 1'b1);
        rd(8'h01, d); chk("R9 nested vector", d, 32'h102);
        rd(8'h04, d); chk("R9 status two deep", d, 32'h502);
        #1 chk("R9 top level blocks all", 32'(irq), 32'd0);
        wr(8'h02, 0);
        rd(8'h04, d); chk("R10 pop to one", d, 32'h201);
        #1 chk("R9 level 5 eligible again", 32'(irq), 32'd1);
        int_src = 4'b0000;
        wr(8'h02, 0);
        rd(8'h04, d); chk("R10 pop to empty", d, 32'h0);
        wr(8'h02, 0);
        rd(8'h04, d); chk("R10 pop on empty ignored", d, 32'h0);

        // ---- R11 fast line ----
        do_reset();
        @(negedge clk); fast_src = 1'b1;
        @(negedge clk); #1 chk("R11 fiq after 1", 32'(fiq), 32'd0);
        @(negedge clk); #1 chk("R11 fiq after 2", 32'(fiq), 32'd1);
        rd(8'h01, d); chk("R11 vector read spurious", d, SPUR);
        #1 chk("R11 fiq unaffected by read", 32'(fiq), 32'd1);
        chk("R11 fiq not on normal line", 32'(irq), 32'd0);
        fast_src = 1'b0;
        @(negedge clk); @(negedge clk);
        #1 chk("R11 fiq falls after 2", 32'(fiq), 32'd0);

        // ---- R12 edge latched while masked ----
        do_reset();
        wr(8'h14, 32'h33);
        @(negedge clk); ext_src[0] = 1'b1;
        @(negedge clk); ext_src[0] = 1'b0;
        repeat (5) @(negedge clk);
        #1 chk("R12 masked edge no irq", 32'(irq), 32'd0);
        rd(8'h03, d); chk("R12 pending latched", d, 32'h10);
        wr(8'h00, 32'h10);
        #1 chk("R12 irq on enable", 32'(irq), 32'd1);
        rd(8'h01, d); chk("R12 vector", d, 32'h104);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule